// File: doc/BRIEF.md
# Clock power-down and wake-up controller

This block is the central clock gating controller of a chip. It drives one enable per peripheral clock domain, one for the processor clock and one for the register-bus clock, plus a select output that says whether the processor and bus clocks come from the PLL or from the crystal reference. Software gates each clock through its own control register, where bit 0 is the enable. The PLLs, dividers and glitch-free multiplexers sit outside the block and only see the enable and select outputs.

To put the whole chip to sleep, software first gates every peripheral clock and then writes a shutdown command word to the processor clock register. The processor clock stops on the edge that takes the command, and the bus clock, the one the command arrived through, stops a fixed number of crystal cycles later. Since the bus is then dead, everything that can bring the chip back runs on the crystal clock: a programmable timer that counts crystal cycles, a GPIO interrupt line and a dedicated GPIO wake pin. Both asynchronous lines go through synchronisers. Any wake brings both clocks back together on the crystal source and records its cause in a sticky status register.

All logic in the block is clocked by the crystal reference. The register port is a plain synchronous port. Writes are taken only while the controller is in its running state.

Top module: `clkpwr_ctrl`

## Requirements
- R1: After reset, every peripheral register reads 0x1 and its enable is high. The processor register reads 0x1 (enabled, crystal source). The bus register reads 0x1. The timer and status registers read 0. The processor and bus enables are high and `core_src_pll` is low.
- R2: The peripheral register at address i (0 to NUM_PERIPH-1) keeps the low CFG_W bits written to it. `periph_clk_en[i]` equals its bit 0 from the edge after the write. Reads return any register on `reg_rdata` one clock after the address is presented.
- R3: A write to the processor register (address NUM_PERIPH) of any value other than the command word keeps bits [1:0]. Bit 0 drives `cpu_clk_en` and bit 1 drives `core_src_pll`.
- R4: Writing the command word 0x00000008 to the processor register, with every peripheral enable at 0, clears `cpu_clk_en` on the edge of the write. `bus_clk_en` stays high for 4 more edges and is low after the 4th.
- R5: A command write while any peripheral enable is 1 is ignored: the processor register, `cpu_clk_en` and `bus_clk_en` stay unchanged.
- R6: From the command edge until the next wake, register writes are ignored. A peripheral register written during the drain keeps its old value after the wake.
- R7: Writing a nonzero value V to the timer register (address NUM_PERIPH+2) arms it. The wake takes effect on the V-th edge after the write edge. Writing 0 disarms it, so no wake follows.
- R8: While powered down or draining, a high level on `gpio_irq_wake` wakes the block on the 3rd edge after the input rises (two synchroniser flops plus one state flop). While running, the line has no effect.
- R9: `gpio15_wake` behaves the same way as `gpio_irq_wake`, with the same 3-edge latency and the same lack of effect while running.
- R10: On a wake, `cpu_clk_en` and `bus_clk_en` rise on the same edge and `core_src_pll` is forced low. The processor register then reads 0x1, and the peripheral enables stay as they were.
- R11: A wake clears the timer register to 0. It also sets one sticky bit per source present on that edge in the status register (address NUM_PERIPH+3): bit 0 for the timer, bit 1 for the GPIO interrupt, bit 2 for the wake pin.
- R12: Writing the status register clears exactly the bits written as 1. All other bits keep their value.
- R13: The bus register (address NUM_PERIPH+1) reads the current bus enable in bit 0 and ignores writes. Addresses above NUM_PERIPH+3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal reference clock; clocks all of the block's logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one clock after the address |
| gpio_irq_wake | input | 1 | Asynchronous GPIO interrupt wake request |
| gpio15_wake | input | 1 | Asynchronous dedicated wake pin |
| periph_clk_en | output | NUM_PERIPH | Enables for the peripheral clock domains |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | 1 | Register-bus clock enable |
| core_src_pll | output | 1 | 1 = processor and bus clocks run from the PLL, 0 = from the crystal |

## Verification
Each result has a fixed edge on which it is due. A write's effect is visible after the edge that samples it. Read data arrives one edge after the address. The bus enable drops on the 4th edge after the command edge, a GPIO-line wake lands on the 3rd edge after the input rises, and a timer wake lands on the V-th edge after the arming write. The bench drives inputs and samples outputs on falling edges. It counts those edges from each stimulus and checks the output on both sides of the edge where it is due: still old one edge early, new on the edge itself.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;

   typedef enum logic [1:0] {
      PWR_RUN   = 2'd0,
      PWR_DRAIN = 2'd1,
      PWR_OFF   = 2'd2
   } pwr_state_e;

   localparam int WSRC_TMR = 0;
   localparam int WSRC_IRQ = 1;
   localparam int WSRC_PIN = 2;
   localparam int NUM_WSRC = 3;

   localparam int NUM_FIXED_REGS = 4;

endpackage

// File: rtl/clkpwr_sync.sv
module clkpwr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkpwr_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i[b]};
         end
      end
      assign sync_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/clkpwr_wake_timer.sv
module clkpwr_wake_timer #(
   parameter int TMR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] load_val_i,
   input  logic             clear_i,
   output logic [TMR_W-1:0] val_o,
   output logic             fire_o
);

   logic [TMR_W-1:0] val_q;
   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] cnt_inc;
   logic             armed;

   assign armed   = (val_q != '0);
   assign cnt_inc = cnt_q + TMR_W'(1);
   assign fire_o  = armed && (cnt_inc == val_q);
   assign val_o   = val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
         cnt_q <= '0;
      end else if (clear_i) begin
         val_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         val_q <= load_val_i;
         cnt_q <= '0;
      end else if (armed) begin
         cnt_q <= cnt_inc;
      end
   end

endmodule

// File: rtl/clkpwr_seq.sv
module clkpwr_seq
   import clkpwr_pkg::*;
#(
   parameter int GAP = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_i,
   input  logic       wake_i,
   output pwr_state_e state_o,
   output logic       run_o,
   output logic       bus_en_o
);

   localparam int GAP_W = $clog2(GAP + 1);

   if (GAP < 1) begin : g_bad_gap
      $error("clkpwr_seq: GAP must be at least 1");
   end

   pwr_state_e       state_q;
   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWR_RUN;
         gap_q   <= '0;
      end else if (wake_i) begin
         state_q <= PWR_RUN;
         gap_q   <= '0;
      end else begin
         case (state_q)
            PWR_RUN: begin
               if (cmd_i) begin
                  state_q <= PWR_DRAIN;
                  gap_q   <= GAP_W'(GAP - 1);
               end
            end
            PWR_DRAIN: begin
               if (gap_q == '0) begin
                  state_q <= PWR_OFF;
               end else begin
                  gap_q <= gap_q - GAP_W'(1);
               end
            end
            PWR_OFF: state_q <= PWR_OFF;
            default: state_q <= PWR_RUN;
         endcase
      end
   end

   assign state_o  = state_q;
   assign run_o    = (state_q == PWR_RUN);
   assign bus_en_o = (state_q != PWR_OFF);

endmodule

// File: rtl/clkpwr_regs.sv
module clkpwr_regs
   import clkpwr_pkg::*;
#(
   parameter int                  NUM_PERIPH   = 4,
   parameter int                  CFG_W        = 4,
   parameter int                  ADDR_W       = 4,
   parameter int                  DATA_W       = 32,
   parameter int                  RD_PIPE      = 1,
   parameter logic [CFG_W-1:0]    PERIPH_RST   = CFG_W'(1),
   parameter logic [DATA_W-1:0]   SHUTDOWN_CMD = DATA_W'(8)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  we_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   input  logic                  run_i,
   input  logic                  bus_en_i,
   input  logic                  wake_i,
   input  logic [NUM_WSRC-1:0]   wake_src_i,
   input  logic [DATA_W-1:0]     tmr_val_i,
   output logic [NUM_PERIPH-1:0] periph_en_o,
   output logic                  cpu_en_o,
   output logic                  src_pll_o,
   output logic                  cmd_go_o,
   output logic                  tmr_wr_o
);

   localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'(NUM_PERIPH);
   localparam logic [ADDR_W-1:0] A_BUS  = ADDR_W'(NUM_PERIPH + 1);
   localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(NUM_PERIPH + 2);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_PERIPH + 3);

   logic                  wr_ok;
   logic                  cpu_sel;
   logic                  is_cmd;
   logic                  all_off;
   logic                  cpu_wr;
   logic                  stat_wr;
   logic [CFG_W-1:0]      pcfg [NUM_PERIPH];
   logic                  cpu_en_q;
   logic                  src_pll_q;
   logic [NUM_WSRC-1:0]   stat_q;
   logic [DATA_W-1:0]     rd_d;

   assign wr_ok   = we_i && run_i;
   assign cpu_sel = wr_ok && (addr_i == A_CPU);
   assign is_cmd  = (wdata_i == SHUTDOWN_CMD);
   assign all_off = ~|periph_en_o;
   assign cmd_go_o = cpu_sel && is_cmd && all_off;
   assign cpu_wr   = cpu_sel && !is_cmd;
   assign tmr_wr_o = wr_ok && (addr_i == A_TMR);
   assign stat_wr  = wr_ok && (addr_i == A_STAT);

   // Peripheral clock control registers, one per domain
   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
      logic [CFG_W-1:0] cfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q <= PERIPH_RST;
         end else if (wr_ok && (addr_i == ADDR_W'(i))) begin
            cfg_q <= wdata_i[CFG_W-1:0];
         end
      end
      assign pcfg[i]        = cfg_q;
      assign periph_en_o[i] = cfg_q[0];
   end

   // Processor clock control register: bit 0 enable, bit 1 source select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_en_q  <= 1'b1;
         src_pll_q <= 1'b0;
      end else if (wake_i) begin
         cpu_en_q  <= 1'b1;
         src_pll_q <= 1'b0;
      end else if (cmd_go_o) begin
         cpu_en_q  <= 1'b0;
      end else if (cpu_wr) begin
         cpu_en_q  <= wdata_i[0];
         src_pll_q <= wdata_i[1];
      end
   end

   // Sticky wake cause, write one to clear, a new cause wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_q & ~(stat_wr ? wdata_i[NUM_WSRC-1:0] : '0)) | wake_src_i;
      end
   end

   assign cpu_en_o  = cpu_en_q;
   assign src_pll_o = src_pll_q;

   always_comb begin
      rd_d = '0;
      for (int i = 0; i < NUM_PERIPH; i++) begin
         if (addr_i == ADDR_W'(i)) begin
            rd_d = DATA_W'(pcfg[i]);
         end
      end
      if (addr_i == A_CPU)  rd_d = DATA_W'({src_pll_q, cpu_en_q});
      if (addr_i == A_BUS)  rd_d = DATA_W'(bus_en_i);
      if (addr_i == A_TMR)  rd_d = tmr_val_i;
      if (addr_i == A_STAT) rd_d = DATA_W'(stat_q);
   end

   if (RD_PIPE != 0) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else begin
            rdata_q <= rd_d;
         end
      end
      assign rdata_o = rdata_q;
   end else begin : g_rd_comb
      assign rdata_o = rd_d;
   end

endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
   import clkpwr_pkg::*;
#(
   parameter int                NUM_PERIPH   = 4,
   parameter int                CFG_W        = 4,
   parameter int                ADDR_W       = 4,
   parameter int                DATA_W       = 32,
   parameter int                TMR_W        = 32,
   parameter int                GAP          = 4,
   parameter int                SYNC_STAGES  = 2,
   parameter int                RD_PIPE      = 1,
   parameter logic [CFG_W-1:0]  PERIPH_RST   = CFG_W'(1),
   parameter logic [DATA_W-1:0] SHUTDOWN_CMD = DATA_W'(8)
) (
   input  logic                  clk_xtal,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_we,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  gpio_irq_wake,
   input  logic                  gpio15_wake,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  cpu_clk_en,
   output logic                  bus_clk_en,
   output logic                  core_src_pll
);

   localparam int NUM_REGS = NUM_PERIPH + NUM_FIXED_REGS;

   if (NUM_PERIPH < 1) begin : g_bad_np
      $error("clkpwr_ctrl: NUM_PERIPH must be at least 1");
   end
   if ((2 ** ADDR_W) < NUM_REGS) begin : g_bad_aw
      $error("clkpwr_ctrl: ADDR_W too small for the register map");
   end
   if (CFG_W < 1 || CFG_W > DATA_W) begin : g_bad_cfg
      $error("clkpwr_ctrl: CFG_W out of range");
   end
   if (TMR_W < 1 || TMR_W > DATA_W) begin : g_bad_tmr
      $error("clkpwr_ctrl: TMR_W out of range");
   end
   if (DATA_W < 4) begin : g_bad_dw
      $error("clkpwr_ctrl: DATA_W must be at least 4");
   end

   logic [1:0]          sync_q;
   logic                irq_s;
   logic                pin_s;
   pwr_state_e          state;
   logic                run;
   logic                cmd_go;
   logic                tmr_wr;
   logic                tmr_fire;
   logic [TMR_W-1:0]    tmr_val;
   logic [DATA_W-1:0]   tmr_val_ext;
   logic [NUM_WSRC-1:0] wake_src;
   logic                wake;

   clkpwr_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk_xtal),
      .rst_n   (rst_n),
      .async_i ({gpio15_wake, gpio_irq_wake}),
      .sync_o  (sync_q)
   );

   assign irq_s = sync_q[0];
   assign pin_s = sync_q[1];

   assign wake_src[WSRC_TMR] = tmr_fire;
   assign wake_src[WSRC_IRQ] = irq_s && !run;
   assign wake_src[WSRC_PIN] = pin_s && !run;
   assign wake               = |wake_src;

   clkpwr_wake_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk        (clk_xtal),
      .rst_n      (rst_n),
      .load_i     (tmr_wr),
      .load_val_i (reg_wdata[TMR_W-1:0]),
      .clear_i    (wake),
      .val_o      (tmr_val),
      .fire_o     (tmr_fire)
   );

   assign tmr_val_ext = DATA_W'(tmr_val);

   clkpwr_seq #(
      .GAP (GAP)
   ) u_seq (
      .clk      (clk_xtal),
      .rst_n    (rst_n),
      .cmd_i    (cmd_go),
      .wake_i   (wake),
      .state_o  (state),
      .run_o    (run),
      .bus_en_o (bus_clk_en)
   );

   clkpwr_regs #(
      .NUM_PERIPH   (NUM_PERIPH),
      .CFG_W        (CFG_W),
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .RD_PIPE      (RD_PIPE),
      .PERIPH_RST   (PERIPH_RST),
      .SHUTDOWN_CMD (SHUTDOWN_CMD)
   ) u_regs (
      .clk         (clk_xtal),
      .rst_n       (rst_n),
      .addr_i      (reg_addr),
      .we_i        (reg_we),
      .wdata_i     (reg_wdata),
      .rdata_o     (reg_rdata),
      .run_i       (run),
      .bus_en_i    (bus_clk_en),
      .wake_i      (wake),
      .wake_src_i  (wake_src),
      .tmr_val_i   (tmr_val_ext),
      .periph_en_o (periph_clk_en),
      .cpu_en_o    (cpu_clk_en),
      .src_pll_o   (core_src_pll),
      .cmd_go_o    (cmd_go),
      .tmr_wr_o    (tmr_wr)
   );

endmodule

// File: rtl/clkpwr_ctrl_chk.sv
module clkpwr_ctrl_chk #(
   parameter int NUM_PERIPH = 4,
   parameter int DATA_W     = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_PERIPH-1:0] periph_clk_en,
   input logic                  cpu_clk_en,
   input logic                  bus_clk_en,
   input logic                  core_src_pll,
   input logic [DATA_W-1:0]     tmr_val
);

   AST_BUS_OFF_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_clk_en |-> !cpu_clk_en); // R4

   AST_CPU_STOPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_clk_en) |-> $past(!cpu_clk_en)); // R4

   AST_SLEEP_PERIPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_clk_en |-> (periph_clk_en == '0)); // R5

   AST_PERIPH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_clk_en |=> $stable(periph_clk_en)); // R6

   AST_WAKE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_clk_en) |-> (cpu_clk_en && !core_src_pll)); // R10

   AST_WAKE_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_clk_en) |-> (tmr_val == '0)); // R11

endmodule

bind clkpwr_ctrl clkpwr_ctrl_chk #(
   .NUM_PERIPH (NUM_PERIPH),
   .DATA_W     (DATA_W)
) u_chk (
   .clk           (clk_xtal),
   .rst_n         (rst_n),
   .periph_clk_en (periph_clk_en),
   .cpu_clk_en    (cpu_clk_en),
   .bus_clk_en    (bus_clk_en),
   .core_src_pll  (core_src_pll),
   .tmr_val       (tmr_val_ext)
);

// File: tb/clkpwr_ctrl_bench.sv
`timescale 1ns/1ps
module clkpwr_ctrl_bench;

   localparam int NP     = 4;
   localparam int AW     = 4;
   localparam int DW     = 32;
   localparam int A_CPU  = NP;
   localparam int A_BUS  = NP + 1;
   localparam int A_TMR  = NP + 2;
   localparam int A_STAT = NP + 3;
   localparam logic [DW-1:0] CMD = 32'h0000_0008;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          gpio_irq_wake = 1'b0;
   logic          gpio15_wake = 1'b0;
   logic [NP-1:0] periph_clk_en;
   logic          cpu_clk_en;
   logic          bus_clk_en;
   logic          core_src_pll;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   clkpwr_ctrl u_clkpwr_ctrl (
      .clk_xtal      (clk),
      .rst_n         (rst_n),
      .reg_addr      (reg_addr),
      .reg_we        (reg_we),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .gpio_irq_wake (gpio_irq_wake),
      .gpio15_wake   (gpio15_wake),
      .periph_clk_en (periph_clk_en),
      .cpu_clk_en    (cpu_clk_en),
      .bus_clk_en    (bus_clk_en),
      .core_src_pll  (core_src_pll)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr  = AW'(a);
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = AW'(a);
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      chk("R1 periph_clk_en", DW'(periph_clk_en), DW'(4'hF));
      chk("R1 cpu_clk_en", DW'(cpu_clk_en), 1);
      chk("R1 bus_clk_en", DW'(bus_clk_en), 1);
      chk("R1 core_src_pll", DW'(core_src_pll), 0);
      for (int i = 0; i < NP; i++) begin
         rd(i, v); chk("R1 periph reg", v, 1);
      end
      rd(A_CPU, v);  chk("R1 cpu reg", v, 1);
      rd(A_BUS, v);  chk("R1 R13 bus reg", v, 1);
      rd(A_TMR, v);  chk("R1 timer reg", v, 0);
      rd(A_STAT, v); chk("R1 status reg", v, 0);
      rd(9, v);      chk("R13 unmapped", v, 0);
   endtask

   task automatic t_periph();
      logic [DW-1:0] v;
      wr(2, 32'h6);
      chk("R2 en2 off", DW'(periph_clk_en), DW'(4'hB));
      rd(2, v); chk("R2 readback", v, 32'h6);
      wr(2, 32'hF5);
      chk("R2 en2 on", DW'(periph_clk_en), DW'(4'hF));
      rd(2, v); chk("R2 readback cfg bits", v, 32'h5);
      wr(A_BUS, 32'h0);
      chk("R13 bus write ignored", DW'(bus_clk_en), 1);
      rd(A_BUS, v); chk("R13 bus reg", v, 1);
   endtask

   task automatic t_cpu();
      logic [DW-1:0] v;
      wr(A_CPU, 32'h3);
      chk("R3 cpu on", DW'(cpu_clk_en), 1);
      chk("R3 pll sel", DW'(core_src_pll), 1);
      rd(A_CPU, v); chk("R3 readback", v, 3);
      wr(A_CPU, 32'h2);
      chk("R3 cpu off", DW'(cpu_clk_en), 0);
      chk("R3 bus stays", DW'(bus_clk_en), 1);
      wr(A_CPU, 32'h1);
      chk("R3 cpu back", DW'(cpu_clk_en), 1);
      chk("R3 xtal sel", DW'(core_src_pll), 0);
   endtask

   task automatic t_cmd_blocked();
      logic [DW-1:0] v;
      wr(A_CPU, CMD);
      repeat (6) @(negedge clk);
      chk("R5 cpu still on", DW'(cpu_clk_en), 1);
      chk("R5 bus still on", DW'(bus_clk_en), 1);
      rd(A_CPU, v); chk("R5 cpu reg kept", v, 1);
   endtask

   task automatic t_disarm_and_irq_active();
      logic [DW-1:0] v;
      wr(A_CPU, 32'h3);
      wr(A_TMR, 32'd5);
      wr(A_TMR, 32'd0);
      repeat (12) @(negedge clk);
      chk("R7 disarmed no wake", DW'(core_src_pll), 1);
      rd(A_STAT, v); chk("R7 no timer status", v, 0);
      @(negedge clk); gpio_irq_wake = 1'b1;
      repeat (6) @(negedge clk);
      gpio_irq_wake = 1'b0;
      gpio15_wake = 1'b1;
      repeat (6) @(negedge clk);
      gpio15_wake = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 R9 ignored while running", DW'(core_src_pll), 1);
      rd(A_STAT, v); chk("R8 R9 no status while running", v, 0);
   endtask

   task automatic t_timer_wake();
      logic [DW-1:0] v;
      for (int i = 0; i < NP; i++) wr(i, 32'h0);
      chk("R4 peripherals off", DW'(periph_clk_en), 0);
      wr(A_TMR, 32'd20);               // edge T0
      wr(A_CPU, CMD);                  // edge T0+2
      chk("R4 cpu off on cmd edge", DW'(cpu_clk_en), 0);
      chk("R4 bus still on", DW'(bus_clk_en), 1);
      repeat (3) @(negedge clk);       // T0+5
      chk("R4 bus on at 3rd edge", DW'(bus_clk_en), 1);
      @(negedge clk);                  // T0+6
      chk("R4 bus off at 4th edge", DW'(bus_clk_en), 0);
      repeat (13) @(negedge clk);      // T0+19
      chk("R7 asleep one edge early", DW'(cpu_clk_en), 0);
      @(negedge clk);                  // T0+20
      chk("R7 R10 cpu on", DW'(cpu_clk_en), 1);
      chk("R10 bus on same edge", DW'(bus_clk_en), 1);
      chk("R10 forced xtal", DW'(core_src_pll), 0);
      chk("R10 periph unchanged", DW'(periph_clk_en), 0);
      rd(A_CPU, v);  chk("R10 cpu reg", v, 1);
      rd(A_TMR, v);  chk("R11 timer cleared", v, 0);
      rd(A_STAT, v); chk("R11 timer status", v, 1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v); chk("R12 cleared", v, 0);
   endtask

   task automatic t_pin_wake();
      logic [DW-1:0] v;
      wr(A_CPU, CMD);                  // edge T
      wr(0, 32'h1);                    // edge T+2, draining
      chk("R6 drain write ignored", DW'(periph_clk_en), 0);
      repeat (2) @(negedge clk);       // T+4
      chk("R4 asleep", DW'(bus_clk_en), 0);
      gpio15_wake = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 not yet awake", DW'(cpu_clk_en), 0);
      @(negedge clk);
      chk("R9 cpu on 3rd edge", DW'(cpu_clk_en), 1);
      chk("R9 R10 bus on", DW'(bus_clk_en), 1);
      gpio15_wake = 1'b0;
      rd(A_STAT, v); chk("R11 pin status", v, 4);
      rd(0, v); chk("R6 periph reg kept", v, 0);
   endtask

   task automatic t_irq_wake();
      logic [DW-1:0] v;
      wr(A_CPU, CMD);
      repeat (6) @(negedge clk);
      chk("R4 asleep again", DW'(bus_clk_en), 0);
      gpio_irq_wake = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 not yet awake", DW'(cpu_clk_en), 0);
      @(negedge clk);
      chk("R8 cpu on 3rd edge", DW'(cpu_clk_en), 1);
      chk("R8 bus on", DW'(bus_clk_en), 1);
      gpio_irq_wake = 1'b0;
      rd(A_STAT, v); chk("R11 sticky irq and pin", v, 6);
      wr(A_STAT, 32'h2);
      rd(A_STAT, v); chk("R12 clear irq only", v, 4);
      wr(A_STAT, 32'h4);
      rd(A_STAT, v); chk("R12 clear pin", v, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_periph();
      t_cpu();
      t_cmd_blocked();
      t_disarm_and_irq_active();
      t_timer_wake();
      t_pin_wake();
      t_irq_wake();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule